// File: doc/BRIEF.md
# Two-Phase Latch Register with Conditional Inversion

This block stores a single bit using two level-sensitive latches placed back to back. Two clocks drive it, `phi1` and `phi2`, and they are never high together. A front latch opens while `phi1` is high. It takes in a next-state value formed from the present output and the data input. A back latch opens while `phi2` is high and passes that captured value to the output `q`. Since the two phases never overlap, the path from `q` back into the next-state logic cannot race around the loop.

Two control inputs choose the next state. `loadEn` picks the source: the stored bit when low, the data input `d` when high. `invEn` complements whichever source was picked. From these two bits come four behaviours: hold, toggle, load, and load-complemented. The select is built as a two-input NAND multiplexer followed by an XOR stage. A parameter can switch the select to a behavioural form.

Top module: `phase_pair_reg`

## Requirements
- R1: With loadEn=0 and invEn=0 during a phi1 pulse, q after the following phi2 pulse equals its value before that phi1 pulse (hold).
- R2: With loadEn=0 and invEn=1 during a phi1 pulse, q after the following phi2 pulse is the complement of its previous value (toggle).
- R3: With loadEn=1 and invEn=0 during a phi1 pulse, q after the following phi2 pulse equals d (load).
- R4: With loadEn=1 and invEn=1 during a phi1 pulse, q after the following phi2 pulse equals the complement of d (load inverted).
- R5: q does not change while phi1 is high, and it still holds its old value after phi1 falls until phi2 rises.
- R6: Changes on loadEn, invEn or d while phi1 is low have no effect on the value q takes after the next phi2 pulse, other than through the inputs present during the next phi1 pulse.
- R7: The front latch is transparent during phi1, so the value stored is set by the inputs present just before phi1 falls, not by earlier values within the same pulse.
- R8: While phi2 is high, q follows the front latch's captured value, and at the fall of phi2 q equals that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi1 | input | 1 | First phase; front latch transparent while high |
| phi2 | input | 1 | Second phase; back latch transparent while high, never high together with phi1 |
| loadEn | input | 1 | 1 selects d as the source, 0 selects the stored bit |
| invEn | input | 1 | 1 complements the selected source |
| d | input | 1 | Data input |
| q | output | 1 | Stored bit |

## Verification
The hardest case to reach is a disturbance on the feedback loop while the back latch is open. The stimulus therefore flips `d`, `loadEn` and `invEn` in the middle of `phi2` pulses and also between phases. It then confirms that `q` reflects only the inputs present during the preceding `phi1`. A second case the stimulus forces is a change of `d` within a single `phi1` pulse. This shows that the value present last before `phi1` falls is the one that sticks.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic takeData;  // source is d instead of stored bit
    logic flip;      // complement the selected source
  } ctrlStrobe_t;

endpackage

// File: rtl/ppr_ctrl.sv
module ppr_ctrl
  import ppr_pkg::*;
(
  input  logic        loadEn,
  input  logic        invEn,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.takeData = loadEn;
    strobe.flip     = invEn;
  end

endmodule

// File: rtl/ppr_datapath.sv
module ppr_datapath
  import ppr_pkg::*;
#(
  parameter bit USE_NAND_MUX = 1'b1
) (
  input  logic        phi1,
  input  logic        phi2,
  input  ctrlStrobe_t strobe,
  input  logic        d,
  output logic        masterVal,
  output logic        q
);

  logic srcSel;
  logic nextVal;

  generate
    if (USE_NAND_MUX) begin : g_nandMux
      logic selBar;
      logic armD;
      logic armQ;
      always_comb begin
        selBar = ~strobe.takeData;
        armD   = ~(strobe.takeData & d);
        armQ   = ~(selBar & q);
        srcSel = ~(armD & armQ);
      end
    end else begin : g_behavMux
      always_comb srcSel = strobe.takeData ? d : q;
    end
  endgenerate

  always_comb nextVal = srcSel ^ strobe.flip;

  // front latch, open during phi1
  always_latch begin
    if (phi1) masterVal = nextVal;
  end

  // back latch, open during phi2
  always_latch begin
    if (phi2) q = masterVal;
  end

endmodule

// File: rtl/phase_pair_reg.sv
module phase_pair_reg
  import ppr_pkg::*;
#(
  parameter bit USE_NAND_MUX = 1'b1
) (
  input  logic phi1,
  input  logic phi2,
  input  logic loadEn,
  input  logic invEn,
  input  logic d,
  output logic q
);

  ctrlStrobe_t strobe;
  logic        masterVal;

  ppr_ctrl u_ctrl (
    .loadEn (loadEn),
    .invEn  (invEn),
    .strobe (strobe)
  );

  ppr_datapath #(
    .USE_NAND_MUX (USE_NAND_MUX)
  ) u_dp (
    .phi1      (phi1),
    .phi2      (phi2),
    .strobe    (strobe),
    .d         (d),
    .masterVal (masterVal),
    .q         (q)
  );

endmodule

// File: rtl/ppr_checker.sv
module ppr_checker (
  input logic phi1,
  input logic phi2,
  input logic loadEn,
  input logic invEn,
  input logic d,
  input logic masterVal,
  input logic q
);

  logic qAtRise;

  always_comb begin
    a_r5_phases_apart: assert (!(phi1 && phi2));
  end

  always_ff @(posedge phi1) qAtRise <= q;

  always_ff @(negedge phi1) begin
    if (!$isunknown(qAtRise) && !$isunknown(q))
      a_r5_q_frozen_in_phi1: assert (q == qAtRise);
  end

  a_r1_hold: assert property (@(negedge phi1) disable iff ($isunknown(q))
    (!loadEn && !invEn) |-> (masterVal == q));

  a_r2_toggle: assert property (@(negedge phi1) disable iff ($isunknown(q))
    (!loadEn && invEn) |-> (masterVal == !q));

  a_r3_load: assert property (@(negedge phi1) disable iff ($isunknown(d))
    (loadEn && !invEn) |-> (masterVal == d));

  a_r4_load_inv: assert property (@(negedge phi1) disable iff ($isunknown(d))
    (loadEn && invEn) |-> (masterVal == !d));

  a_r8_slave_follows: assert property (@(negedge phi2) disable iff ($isunknown(masterVal))
    1'b1 |-> (q == masterVal));

endmodule

bind phase_pair_reg ppr_checker u_chk (
  .phi1      (phi1),
  .phi2      (phi2),
  .loadEn    (loadEn),
  .invEn     (invEn),
  .d         (d),
  .masterVal (masterVal),
  .q         (q)
);

// File: tb/tb_phase_pair_reg.sv
`timescale 1ns/1ps
module tb_phase_pair_reg;

  logic phi1 = 1'b0;
  logic phi2 = 1'b0;
  logic loadEn = 1'b0;
  logic invEn = 1'b0;
  logic d = 1'b0;
  logic q;

  int checks = 0;
  int failures = 0;
  bit expQ;
  bit done = 1'b0;

  typedef struct {
    bit    val;
    string req;
  } expItem_t;
  expItem_t expQueue[$];

  phase_pair_reg dut (
    .phi1   (phi1),
    .phi2   (phi2),
    .loadEn (loadEn),
    .invEn  (invEn),
    .d      (d),
    .q      (q)
  );

  task automatic check(input logic act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s q=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one 5 ns cycle: inputs at 0, phi1 1..2, phi2 3..4
  // disturbPhi2: scramble inputs during phi2 (R6); lateD: change d in phi1 (R7)
  task automatic runCycle(input bit ld, input bit iv, input bit dv,
                          input string req, input bit disturbPhi2,
                          input bit lateD);
    expItem_t it;
    bit dFinal;
    loadEn = ld; invEn = iv;
    dFinal = dv;
    d = lateD ? !dv : dv;
    #1 phi1 = 1'b1;
    if (lateD) begin
      #0.5 d = dv;
      #0.5 phi1 = 1'b0;
    end else begin
      #1 phi1 = 1'b0;
    end
    #0.5;
    check(q, expQ, "R5 q unchanged before phi2");
    case ({ld, iv})
      2'b00: expQ = expQ;
      2'b01: expQ = !expQ;
      2'b10: expQ = dFinal;
      default: expQ = !dFinal;
    endcase
    it.val = expQ;
    it.req = req;
    expQueue.push_back(it);
    #0.5 phi2 = 1'b1;
    if (disturbPhi2) begin
      #0.3 d = !d; loadEn = !loadEn;
      #0.3 invEn = !invEn;
      #0.4 phi2 = 1'b0;
    end else begin
      #1 phi2 = 1'b0;
    end
    #1;
  endtask

  // monitor: compare after each phi2 pulse completes
  initial begin
    forever begin
      @(negedge phi2);
      #0.5;
      if (expQueue.size() != 0) begin
        expItem_t it;
        it = expQueue.pop_front();
        check(q, it.val, it.req);
      end
    end
  end

  initial begin
    // first cycle: load establishes a known value
    expQ = 1'b0;
    loadEn = 1'b1; d = 1'b1;
    #1 phi1 = 1'b1; #1 phi1 = 1'b0;
    #1 phi2 = 1'b1; #1 phi2 = 1'b0;
    #0.5;
    check(q, 1'b1, "R3 initial load");
    expQ = 1'b1;
    #0.5;

    runCycle(1'b0, 1'b0, 1'b0, "R1 hold one", 1'b0, 1'b0);
    runCycle(1'b0, 1'b1, 1'b1, "R2 toggle to zero", 1'b0, 1'b0);
    runCycle(1'b0, 1'b0, 1'b1, "R1 hold zero", 1'b0, 1'b0);
    runCycle(1'b0, 1'b1, 1'b0, "R2 toggle to one", 1'b0, 1'b0);
    runCycle(1'b1, 1'b0, 1'b0, "R3 load zero", 1'b0, 1'b0);
    runCycle(1'b1, 1'b0, 1'b1, "R3 load one", 1'b0, 1'b0);
    runCycle(1'b1, 1'b1, 1'b1, "R4 load inverted one", 1'b0, 1'b0);
    runCycle(1'b1, 1'b1, 1'b0, "R4 load inverted zero", 1'b0, 1'b0);
    runCycle(1'b0, 1'b0, 1'b0, "R6 hold with phi2 disturbance", 1'b1, 1'b0);
    runCycle(1'b0, 1'b1, 1'b0, "R6 toggle with phi2 disturbance", 1'b1, 1'b0);
    runCycle(1'b1, 1'b0, 1'b0, "R6 load with phi2 disturbance", 1'b1, 1'b0);
    runCycle(1'b1, 1'b0, 1'b1, "R7 late d in phi1", 1'b0, 1'b1);
    runCycle(1'b1, 1'b1, 1'b1, "R7 late d inverted", 1'b0, 1'b1);
    runCycle(1'b0, 1'b1, 1'b1, "R8 toggle", 1'b0, 1'b0);
    runCycle(1'b0, 1'b1, 1'b1, "R8 toggle again", 1'b0, 1'b0);

    // R6: inputs wiggle with both phases low; q must stay
    d = !d; loadEn = 1'b1; invEn = 1'b1;
    #1 d = !d;
    #0.5;
    check(q, expQ, "R6 idle input change");
    #0.5;

    for (int i = 0; i < 40; i++) begin
      bit ld = i[0] ^ i[3];
      bit iv = i[1];
      bit dv = i[2] ^ i[0];
      runCycle(ld, iv, dv, "R1 R2 R3 R4 mixed", i[2], i[4]);
    end

    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule